// File: doc/BRIEF.md
# Logical-Block Storage Controller with DMA Delivery

The controller presents a storage surface as a flat run of fixed-size logical blocks numbered from 0. The host starts a transfer through a small register port. It loads a block number and a destination memory address, then writes a read command. The controller turns the block number into a physical (surface, track, sector) triple. It does this by walking a zone table in which every recording zone has its own sectors-per-track count and a few trailing spare tracks that hold no logical blocks. It then streams the sector into memory as 32-bit DMA writes and raises an interrupt when the last word is accepted.

The sector contents come from a behavioural store that synthesises each word from the physical location it was read from. This makes every DMA word show where the translation landed. The geometry (zone count, tracks, spares and sectors per track for each zone, surface count) and the sector size are parameters. The defaults are 2 surfaces and 3 zones, with tracks {4,3,3}, spares {1,1,1}, sectors per track {6,5,4} and 512-byte sectors. That gives 72 logical blocks.

Top module: `lblk_dma_ctrl`

## Requirements
- R1: After reset the status word reads 0, `irq` is low and `dmaValid` is low.
- R2: Writing value 0x01 in bits [7:0] to register offset 0 while idle starts a read, and status bit 0 (busy) reads 1 from the next cycle. Any other command code written while idle is ignored and leaves busy at 0 with no DMA activity.
- R3: A block number is placed by subtracting whole zone capacities ((tracks−spares)·surfaces·sectors) in zone order. Inside the zone, track = zone start track + q / (surfaces·sectors), surface = (q mod surfaces·sectors) / sectors, and sector = q mod sectors. Register offset 0 reads the result as {surface[31:28], track[27:16], sector[15:8], 8'h00}.
- R4: The last `spare` tracks of every zone receive no logical block. The first block of zone z+1 lands on the first track after all tracks of zone z, spares included.
- R5: A block number at or beyond the formatted capacity produces no DMA word, and the transfer ends with status bits 2 (range error) and 1 (done) set and `irq` high.
- R6: A sector is delivered as SECTOR_BYTES/4 DMA words. Word k goes to destination + 4·k and carries {surface[31:28], track[27:16], sector[15:8], k[7:0]}.
- R7: While `dmaValid` is high and `dmaReady` is low, the address and data hold and valid stays high.
- R8: After the last word is accepted, status bit 1 (done) and `irq` go high and busy drops.
- R9: Writing a 1 to status bit 1, 2 or 3 at offset 3 clears that bit. Clearing bit 1 drops `irq`. Writing 0 bits changes nothing.
- R10: A command write during a transfer is rejected and sets status bit 3. Writes to the block number (offset 1) and address (offset 2) registers during a transfer are ignored, and the transfer in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset: 0 command/triple, 1 block number, 2 destination, 3 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| dmaValid | output | 1 | DMA write request |
| dmaReady | input | 1 | DMA write accepted |
| dmaAddr | output | 32 | DMA byte address |
| dmaData | output | 32 | DMA write data |
| irq | output | 1 | Interrupt, high while done is set |

## Verification
The bench aims at the block numbers at the edges of each zone. A translator that forgot the spare tracks would put block 36 on track 3 rather than track 4. One that got the zone order wrong would give the wrong sector count for block 71. Block 72, just past capacity, must raise a range error with no DMA write, and an off-by-one bound would either stream a bogus sector or reject block 71. Backpressure patterns check that a stalled word neither advances nor skips. A command and a block-number write issued mid-transfer must leave the data words untouched while the reject flag is set.

// File: rtl/lblk_pkg.sv
package lblk_pkg;
  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_LBN  = 2'd1;
  localparam logic [1:0] REG_DEST = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
  localparam logic [7:0] CMD_READ = 8'h01;

  localparam int SURF_W = 4;
  localparam int TRK_W  = 12;
  localparam int SEC_W  = 8;
  localparam int WIDX_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_ZONE, ST_TRACK, ST_SURF, ST_XFER} walkState_t;

  typedef struct packed {
    logic walkInit;
    logic zoneStep;
    logic trackStep;
    logic surfStep;
    logic wordStep;
  } dpStrobe_t;

  typedef struct packed {
    logic inZone;
    logic lastZone;
    logic inTrack;
    logic inSurf;
    logic lastWord;
  } dpFlag_t;
endpackage

// File: rtl/lblk_datapath.sv
module lblk_datapath
  import lblk_pkg::*;
#(
  parameter int NSURF = 2,
  parameter int NZONE = 3,
  parameter int ZONE_TRK   [NZONE] = '{4, 3, 3},
  parameter int ZONE_SPARE [NZONE] = '{1, 1, 1},
  parameter int ZONE_SPT   [NZONE] = '{6, 5, 4},
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        busy,
  input  logic        dmaValid,
  input  logic        dmaReady,
  input  dpStrobe_t   strobe,
  output dpFlag_t     flag,
  output logic [31:0] dmaAddr,
  output logic [31:0] dmaData,
  output logic [31:0] lbnReg,
  output logic [31:0] destReg,
  output logic [31:0] tripleWord
);
  localparam int ZW    = (NZONE > 1) ? $clog2(NZONE) : 1;
  localparam int WORDS = SECTOR_BYTES / 4;

  logic [31:0]       remBlk;
  logic [ZW-1:0]     zoneIdx;
  logic [TRK_W-1:0]  trkBase;
  logic [TRK_W-1:0]  trkIdx;
  logic [SURF_W-1:0] surfIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic [31:0]       curSpt, curTrk, curCap, trackCap;
  logic [TRK_W-1:0]  physTrk;

  always_comb begin
    curSpt = 32'd1;
    curTrk = 32'd0;
    curCap = 32'd0;
    for (int z = 0; z < NZONE; z++) begin
      if (zoneIdx == ZW'(z)) begin
        curSpt = 32'(ZONE_SPT[z]);
        curTrk = 32'(ZONE_TRK[z]);
        curCap = 32'((ZONE_TRK[z] - ZONE_SPARE[z]) * NSURF * ZONE_SPT[z]);
      end
    end
    trackCap = curSpt * 32'(NSURF);
  end

  assign flag.inZone   = remBlk < curCap;
  assign flag.lastZone = zoneIdx == ZW'(NZONE - 1);
  assign flag.inTrack  = remBlk < trackCap;
  assign flag.inSurf   = remBlk < curSpt;
  assign flag.lastWord = wordIdx == WIDX_W'(WORDS - 1);

  assign physTrk    = trkBase + trkIdx;
  assign tripleWord = {surfIdx, physTrk, remBlk[SEC_W-1:0], 8'h00};
  assign dmaData    = {surfIdx, physTrk, remBlk[SEC_W-1:0], wordIdx};
  assign dmaAddr    = destReg + {22'd0, wordIdx, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lbnReg  <= '0;
      destReg <= '0;
      remBlk  <= '0;
      zoneIdx <= '0;
      trkBase <= '0;
      trkIdx  <= '0;
      surfIdx <= '0;
      wordIdx <= '0;
    end else begin
      if (regWrEn && !busy && regAddr == REG_LBN)  lbnReg  <= regWrData;
      if (regWrEn && !busy && regAddr == REG_DEST) destReg <= regWrData;
      if (strobe.walkInit) begin
        remBlk  <= lbnReg;
        zoneIdx <= '0;
        trkBase <= '0;
        trkIdx  <= '0;
        surfIdx <= '0;
        wordIdx <= '0;
      end
      if (strobe.zoneStep) begin
        remBlk  <= remBlk - curCap;
        trkBase <= trkBase + curTrk[TRK_W-1:0];
        zoneIdx <= zoneIdx + 1'b1;
      end
      if (strobe.trackStep) begin
        remBlk <= remBlk - trackCap;
        trkIdx <= trkIdx + 1'b1;
      end
      if (strobe.surfStep) begin
        remBlk  <= remBlk - curSpt;
        surfIdx <= surfIdx + 1'b1;
      end
      if (strobe.wordStep) wordIdx <= wordIdx + 1'b1;
    end
  end

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && !dmaReady) |=> (dmaValid && $stable(dmaAddr) && $stable(dmaData))); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && dmaReady && !flag.lastWord) |=> (dmaValid && dmaAddr == $past(dmaAddr) + 32'd4)); // R6
  AST_SURF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> (32'(surfIdx) < 32'(NSURF) && {24'd0, remBlk[SEC_W-1:0]} < curSpt)); // R3
endmodule

// File: rtl/lblk_ctrl.sv
module lblk_ctrl
  import lblk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        dmaReady,
  input  dpFlag_t     flag,
  output dpStrobe_t   strobe,
  output logic        dmaValid,
  output logic        busy,
  output logic [3:0]  status,
  output logic        irq
);
  walkState_t state;
  logic doneFlag, rangeErr, rejectErr;
  logic cmdWr, statWr;

  assign cmdWr    = regWrEn && regAddr == REG_CMD;
  assign statWr   = regWrEn && regAddr == REG_STAT;
  assign busy     = state != ST_IDLE;
  assign dmaValid = state == ST_XFER;
  assign irq      = doneFlag;
  assign status   = {rejectErr, rangeErr, doneFlag, busy};

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:  strobe.walkInit  = cmdWr && regWrData[7:0] == CMD_READ;
      ST_ZONE:  strobe.zoneStep  = !flag.inZone && !flag.lastZone;
      ST_TRACK: strobe.trackStep = !flag.inTrack;
      ST_SURF:  strobe.surfStep  = !flag.inSurf;
      ST_XFER:  strobe.wordStep  = dmaReady && !flag.lastWord;
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneFlag  <= 1'b0;
      rangeErr  <= 1'b0;
      rejectErr <= 1'b0;
    end else begin
      if (statWr) begin
        if (regWrData[1]) doneFlag  <= 1'b0;
        if (regWrData[2]) rangeErr  <= 1'b0;
        if (regWrData[3]) rejectErr <= 1'b0;
      end
      if (busy && cmdWr) rejectErr <= 1'b1;
      unique case (state)
        ST_IDLE: if (strobe.walkInit) begin
          state    <= ST_ZONE;
          doneFlag <= 1'b0;
        end
        ST_ZONE: begin
          if (flag.inZone) state <= ST_TRACK;
          else if (flag.lastZone) begin
            state    <= ST_IDLE;
            rangeErr <= 1'b1;
            doneFlag <= 1'b1;
          end
        end
        ST_TRACK: if (flag.inTrack) state <= ST_SURF;
        ST_SURF:  if (flag.inSurf) state <= ST_XFER;
        ST_XFER: if (dmaReady && flag.lastWord) begin
          state    <= ST_IDLE;
          doneFlag <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy); // R8
  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr) |=> status[3]); // R10
  AST_RANGE_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ZONE && !flag.inZone && flag.lastZone) |=> (!dmaValid && irq && status[2])); // R5
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && dmaReady && flag.lastWord) |=> (irq && !busy)); // R8
endmodule

// File: rtl/lblk_dma_ctrl.sv
module lblk_dma_ctrl
  import lblk_pkg::*;
#(
  parameter int NSURF = 2,
  parameter int NZONE = 3,
  parameter int ZONE_TRK   [NZONE] = '{4, 3, 3},
  parameter int ZONE_SPARE [NZONE] = '{1, 1, 1},
  parameter int ZONE_SPT   [NZONE] = '{6, 5, 4},
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        dmaValid,
  input  logic        dmaReady,
  output logic [31:0] dmaAddr,
  output logic [31:0] dmaData,
  output logic        irq
);
  dpStrobe_t   strobe;
  dpFlag_t     flag;
  logic        busy;
  logic [3:0]  status;
  logic [31:0] lbnReg, destReg, tripleWord;

  lblk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dmaReady(dmaReady), .flag(flag), .strobe(strobe),
    .dmaValid(dmaValid), .busy(busy), .status(status), .irq(irq)
  );

  lblk_datapath #(
    .NSURF(NSURF), .NZONE(NZONE), .ZONE_TRK(ZONE_TRK), .ZONE_SPARE(ZONE_SPARE),
    .ZONE_SPT(ZONE_SPT), .SECTOR_BYTES(SECTOR_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .busy(busy), .dmaValid(dmaValid), .dmaReady(dmaReady),
    .strobe(strobe), .flag(flag), .dmaAddr(dmaAddr), .dmaData(dmaData),
    .lbnReg(lbnReg), .destReg(destReg), .tripleWord(tripleWord)
  );

  always_comb begin
    unique case (regAddr)
      REG_CMD:  regRdData = tripleWord;
      REG_LBN:  regRdData = lbnReg;
      REG_DEST: regRdData = destReg;
      default:  regRdData = {28'd0, status};
    endcase
  end
endmodule

// File: tb/lblk_dma_ctrl_tb.sv
module lblk_dma_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        dmaValid, dmaReady = 1'b0;
  logic [31:0] dmaAddr, dmaData;
  logic        irq;
  int vecCnt = 0;
  int errCnt = 0;

  localparam int WORDS = 128;
  localparam int NS = 2;
  localparam int TRK [3] = '{4, 3, 3};
  localparam int SPR [3] = '{1, 1, 1};
  localparam int SPT [3] = '{6, 5, 4};

  always #4 clk = ~clk;

  lblk_dma_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaValid(dmaValid),
    .dmaReady(dmaReady), .dmaAddr(dmaAddr), .dmaData(dmaData), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] model(input int lbn, output bit ok);
    int base = 0;
    int rem = lbn;
    ok = 0;
    model = 32'd0;
    for (int z = 0; z < 3; z++) begin
      int cap = (TRK[z] - SPR[z]) * NS * SPT[z];
      if (!ok && rem < cap) begin
        int per = NS * SPT[z];
        int r = rem % per;
        ok = 1;
        model = {4'(r / SPT[z]), 12'(base + rem / per), 8'(r % SPT[z]), 8'h00};
      end else if (!ok) begin
        rem -= cap;
        base += TRK[z];
      end
    end
  endfunction

  task automatic startXfer(input int lbn, input logic [31:0] dest);
    regWrite(2'd1, 32'(lbn));
    regWrite(2'd2, dest);
    regWrite(2'd0, 32'h1);
  endtask

  task automatic drainXfer(input int lbn, input logic [31:0] dest, input int mode, input string req);
    bit ok;
    logic [31:0] trip, st;
    int k = 0;
    int cyc = 0;
    bit prevStall = 0;
    logic [31:0] prevA = 0, prevD = 0;
    trip = model(lbn, ok);
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (irq) break;
      dmaReady = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (cyc % 5 == 0);
      #1;
      if (prevStall) check(dmaValid && dmaAddr == prevA && dmaData == prevD, "R7 hold", dmaData, prevD);
      if (dmaValid && dmaReady) begin
        check(dmaAddr == dest + 32'(4 * k) && dmaData == (trip | 32'(k)), {req, " R6 word"}, dmaData, trip | 32'(k));
        k++;
      end
      prevStall = dmaValid && !dmaReady;
      prevA = dmaAddr; prevD = dmaData;
    end
    dmaReady = 1'b0;
    check(k == WORDS, "R6 word count", 32'(k), 32'(WORDS));
    regRead(2'd3, st);
    check(st[2:0] == 3'b010 && irq, "R8 done status", st, 32'h2);
    regRead(2'd0, trip);
    check(trip == model(lbn, ok), {req, " triple readback"}, trip, model(lbn, ok));
  endtask

  task automatic clearDone();
    logic [31:0] st;
    regWrite(2'd3, 32'h0);
    regRead(2'd3, st);
    check(st[1] && irq, "R9 zero write no effect", st, 32'h2);
    regWrite(2'd3, 32'h2);
    regRead(2'd3, st);
    check(!st[1] && !irq, "R9 clear done", st, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] st;
    regRead(2'd3, st);
    check(st == 0 && !irq && !dmaValid, "R1 reset", st, 32'h0);
  endtask

  task automatic testStartAndTranslate(input int lbn, input int mode, input string req);
    logic [31:0] st;
    startXfer(lbn, 32'h1000_0000 + 32'(lbn * 1024));
    regRead(2'd3, st);
    check(st[0] == 1'b1, "R2 busy after command", st, 32'h1);
    drainXfer(lbn, 32'h1000_0000 + 32'(lbn * 1024), mode, req);
    clearDone();
  endtask

  task automatic testUnknownCode();
    logic [31:0] st;
    regWrite(2'd1, 32'd5);
    regWrite(2'd0, 32'h2);
    repeat (6) @(negedge clk);
    regRead(2'd3, st);
    check(st == 0 && !dmaValid && !irq, "R2 unknown code ignored", st, 32'h0);
  endtask

  task automatic testRange();
    logic [31:0] st;
    bit sawDma = 0;
    dmaReady = 1'b1;
    startXfer(72, 32'h2000_0000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dmaValid) sawDma = 1;
    end
    dmaReady = 1'b0;
    check(!sawDma, "R5 no DMA on range error", 32'(sawDma), 32'h0);
    regRead(2'd3, st);
    check(st == 32'h6 && irq, "R5 range status", st, 32'h6);
    regWrite(2'd3, 32'h6);
    regRead(2'd3, st);
    check(st == 0 && !irq, "R9 clear range error", st, 32'h0);
  endtask

  task automatic testReject();
    logic [31:0] st;
    dmaReady = 1'b0;
    startXfer(13, 32'h3000_0000);
    repeat (10) @(negedge clk);
    regWrite(2'd0, 32'h1);
    regWrite(2'd1, 32'd50);
    regWrite(2'd2, 32'h4000_0000);
    regRead(2'd3, st);
    check(st[3] && st[0], "R10 reject flag while busy", st, 32'h9);
    regRead(2'd1, st);
    check(st == 32'd13, "R10 LBN write ignored while busy", st, 32'd13);
    drainXfer(13, 32'h3000_0000, 1, "R10 transfer unchanged");
    regWrite(2'd3, 32'ha);
    regRead(2'd3, st);
    check(st == 0 && !irq, "R9 clear reject and done", st, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStartAndTranslate(0,  0, "R3 block 0");
    testStartAndTranslate(13, 1, "R3 block 13");
    testStartAndTranslate(35, 2, "R3 zone0 last block");
    testStartAndTranslate(36, 0, "R4 zone1 first block skips spare");
    testStartAndTranslate(55, 1, "R4 zone1 last block");
    testStartAndTranslate(56, 0, "R4 zone2 first block");
    testStartAndTranslate(71, 2, "R3 last valid block");
    testUnknownCode();
    testRange();
    testReject();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule